// File: doc/BRIEF.md
# Rate 1/n Convolutional Encoder

This block turns a serial bit stream into a rate 1/n convolutional code. It takes one bit per clock. It keeps the previous K-1 accepted bits as its state. For each accepted bit it forms n coded bits, and each coded bit is the XOR of the taps chosen by one generator polynomial. The constraint length K, the output count n and the polynomials are fixed at elaboration time. Typical uses are the K=3 code with polynomials 111/101 and the K=7 code with polynomials 171/133 (octal). The encoder feeds a modulator, and the receiver's Viterbi decoder undoes the code.

The input is a valid/ready stream. A bit is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. The block never applies back-pressure: `in_ready` is low only while reset is held, and through the first clock edge after reset is released. After that it stays high. The output is a valid-qualified word with no ready signal, so the consumer must take every word on the cycle it is marked valid. A cycle with no accepted input leaves the state unchanged and produces no output word. The delay from input to output is fixed, and it depends only on K.

Top module: `conv_enc_top`

## Requirements
- R1: The state holds the last K-1 accepted input bits, and reset clears it to all zeros, so the first word after reset is coded as if every earlier input were 0.
- R2: Each coded bit is the XOR of the window bits selected by the 1 bits of its K-bit polynomial. The polynomial MSB selects the present input, bit K-2 selects the previous accepted bit, and bit 0 selects the oldest stored bit.
- R3: `out_code` is NUM_OUT bits wide, and bit i comes from polynomial i. Polynomial i sits right-aligned in bits [12i+11:12i] of `GEN_POLYS`.
- R4: With K=3, poly0=111 and poly1=101, the inputs 1,0,1,1,0,0 from reset give `out_code` values 3,1,0,2,2,3. Here bit 0 is the poly0 output.
- R5: With K=7, poly0=171 and poly1=133 (octal), a single 1 followed by zeros from reset gives `out_code` values 3,1,3,3,0,2,3.
- R6: A word accepted on clock edge e appears on the outputs after edge e+L-1, where L is 3 for K>4 and 2 for K<=4.
- R7: A cycle without an accepted input changes neither the state nor any later coded word, and it produces no output word.
- R8: `out_valid` is high exactly L cycles after each accepted input and low otherwise, including during reset.
- R9: `in_ready` is low during reset and high from the first clock edge after reset is released.
- R10: Asserting `rst_n` low clears `out_valid` and `in_ready` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one input bit per cycle at most |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input bit offered |
| in_data | input | 1 | Input bit |
| in_ready | output | 1 | Encoder accepts a bit this cycle |
| out_valid | output | 1 | `out_code` holds a coded word |
| out_code | output | NUM_OUT | Coded word, bit i from polynomial i |

## Verification
A wrong state bit shows up in the next coded word whose polynomial taps that bit. With the test polynomials, every stored bit is tapped within K-1 accepted inputs, so an error reaches the ports within K-1 words plus the fixed latency. A state that moves on an idle cycle shifts every later word. This shows within a few cycles when gaps are scattered through the input. The bench sweeps three small configurations: K=3, K=5 with three outputs, and K=7. It feeds every 6-bit input pattern plus random valid gaps, and compares each word with an independently computed delay-by-delay XOR sum.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
  localparam int CE_MAX_K   = 12;
  localparam int CE_MAX_OUT = 8;
  localparam int CE_POLY_W  = CE_MAX_K * CE_MAX_OUT;

  // Pipeline depth from input acceptance to output word.
  function automatic int ce_latency(input int k);
    return (k > 4) ? 3 : 2;
  endfunction
endpackage

// File: rtl/conv_enc_state.sv
module conv_enc_state #(
  parameter int CONSTR_LEN = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  advance,
  input  logic                  bit_in,
  output logic [CONSTR_LEN-2:0] hist
);
  localparam int HW = CONSTR_LEN - 1;

  // hist[HW-1] is the most recent accepted bit, hist[0] the oldest.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else if (advance) hist <= {bit_in, hist[HW-1:1]};
  end

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(hist));

  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (hist[HW-1] == $past(bit_in)) && (hist[HW-2:0] == $past(hist[HW-1:1])));
endmodule

// File: rtl/conv_enc_taps.sv
module conv_enc_taps
  import conv_enc_pkg::*;
#(
  parameter int                   CONSTR_LEN = 7,
  parameter int                   NUM_OUT    = 2,
  parameter logic [CE_POLY_W-1:0] GEN_POLYS  = '0
) (
  input  logic [CONSTR_LEN-1:0] window,
  output logic [NUM_OUT-1:0]    code
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_tap
    localparam logic [CONSTR_LEN-1:0] SEL = GEN_POLYS[g*CE_MAX_K +: CONSTR_LEN];
    assign code[g] = ^(window & SEL);
  end
endmodule

// File: rtl/conv_enc_delay.sv
module conv_enc_delay #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data
);
  logic [DEPTH-1:0] vld;
  logic [WIDTH-1:0] dat [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < DEPTH; i++) dat[i] <= '0;
    end else begin
      vld    <= {vld[DEPTH-2:0], in_valid};
      dat[0] <= in_data;
      for (int i = 1; i < DEPTH; i++) dat[i] <= dat[i-1];
    end
  end

  assign out_valid = vld[DEPTH-1];
  assign out_data  = dat[DEPTH-1];
endmodule

// File: rtl/conv_enc_top.sv
module conv_enc_top
  import conv_enc_pkg::*;
#(
  parameter int                   CONSTR_LEN = 7,
  parameter int                   NUM_OUT    = 2,
  parameter logic [CE_POLY_W-1:0] GEN_POLYS  = {72'd0, 12'o133, 12'o171}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_data,
  output logic               in_ready,
  output logic               out_valid,
  output logic [NUM_OUT-1:0] out_code
);
  localparam int LAT = ce_latency(CONSTR_LEN);

  logic                  accept;
  logic [CONSTR_LEN-2:0] hist;
  logic [NUM_OUT-1:0]    code_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_ready <= 1'b0;
    else in_ready <= 1'b1;
  end

  assign accept = in_valid & in_ready;

  conv_enc_state #(.CONSTR_LEN(CONSTR_LEN)) u_state (
    .clk(clk), .rst_n(rst_n), .advance(accept), .bit_in(in_data), .hist(hist)
  );

  conv_enc_taps #(.CONSTR_LEN(CONSTR_LEN), .NUM_OUT(NUM_OUT), .GEN_POLYS(GEN_POLYS)) u_taps (
    .window({in_data, hist}), .code(code_c)
  );

  conv_enc_delay #(.WIDTH(NUM_OUT), .DEPTH(LAT)) u_delay (
    .clk(clk), .rst_n(rst_n), .in_valid(accept), .in_data(code_c),
    .out_valid(out_valid), .out_data(out_code)
  );

  p_ready_after_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> in_ready);

  p_valid_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(accept, LAT));

  p_code_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_code == $past(code_c, LAT)));

  p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && !in_ready));
endmodule

// File: tb/test_conv_enc_top.sv
`timescale 1ns/1ps
module test_conv_enc_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [2:0] vin = 3'b0;
  logic [2:0] din = 3'b0;
  logic [2:0] rdy, ov;
  logic [1:0] oc_a, oc_b;
  logic [2:0] oc_c;
  logic [7:0] oc [3];

  assign oc[0] = {6'd0, oc_a};
  assign oc[1] = {6'd0, oc_b};
  assign oc[2] = {5'd0, oc_c};

  conv_enc_top #(.CONSTR_LEN(3), .NUM_OUT(2), .GEN_POLYS({72'd0, 12'b101, 12'b111})) i_conv_enc_top (
    .clk(clk), .rst_n(rst_n), .in_valid(vin[0]), .in_data(din[0]),
    .in_ready(rdy[0]), .out_valid(ov[0]), .out_code(oc_a));
  conv_enc_top i_conv_enc_top_k7 (
    .clk(clk), .rst_n(rst_n), .in_valid(vin[1]), .in_data(din[1]),
    .in_ready(rdy[1]), .out_valid(ov[1]), .out_code(oc_b));
  conv_enc_top #(.CONSTR_LEN(5), .NUM_OUT(3),
                 .GEN_POLYS({60'd0, 12'b10101, 12'b11101, 12'b10011})) i_conv_enc_top_k5 (
    .clk(clk), .rst_n(rst_n), .in_valid(vin[2]), .in_data(din[2]),
    .in_ready(rdy[2]), .out_valid(ov[2]), .out_code(oc_c));

  // Reference configuration, written independently of the RTL.
  int         kc [3] = '{3, 7, 5};
  int         nc [3] = '{2, 2, 3};
  logic [11:0] pc [3][3];
  initial begin
    pc[0][0] = 12'b111;   pc[0][1] = 12'b101;   pc[0][2] = 12'b0;
    pc[1][0] = 12'o171;   pc[1][1] = 12'o133;   pc[1][2] = 12'b0;
    pc[2][0] = 12'b10011; pc[2][1] = 12'b11101; pc[2][2] = 12'b10101;
  end

  int nchk = 0, nfail = 0;
  logic        model_ready = 1'b0;
  logic [15:0] hist [3];
  logic        mv [3][4];
  logic [7:0]  mc [3][4];
  bit          capture = 0;
  int          ncap [3];
  logic [7:0]  cap [3][8];

  function automatic int lat_of(input int k);
    return (k > 4) ? 3 : 2;
  endfunction

  // hist[c][d] is the input bit d accepted words ago (0 = present).
  function automatic logic [7:0] ref_code(input int c);
    logic [7:0] r = '0;
    for (int o = 0; o < nc[c]; o++)
      for (int dly = 0; dly < kc[c]; dly++)
        if (pc[c][o][kc[c]-1-dly]) r[o] = r[o] ^ hist[c][dly];
    return r;
  endfunction

  task automatic clear_model();
    model_ready = 1'b0;
    for (int c = 0; c < 3; c++) begin
      hist[c] = '0;
      for (int s = 0; s < 4; s++) begin mv[c][s] = 1'b0; mc[c][s] = '0; end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) clear_model();
    else begin
      for (int c = 0; c < 3; c++) begin
        for (int s = 3; s > 0; s--) begin mv[c][s] = mv[c][s-1]; mc[c][s] = mc[c][s-1]; end
        mv[c][0] = vin[c] & model_ready;
        if (mv[c][0]) begin
          hist[c] = {hist[c][14:0], din[c]};
          mc[c][0] = ref_code(c);
        end
      end
      model_ready = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    for (int c = 0; c < 3; c++) begin
      logic ev;
      ev = mv[c][lat_of(kc[c])-1];
      chk(ov[c] == ev, "R8 out_valid", {7'd0, ov[c]}, {7'd0, ev});
      chk(rdy[c] == model_ready, "R9 in_ready", {7'd0, rdy[c]}, {7'd0, model_ready});
      if (ev)
        chk(oc[c] == mc[c][lat_of(kc[c])-1], (c == 2) ? "R3 R7 code" : "R2 R7 code",
            oc[c], mc[c][lat_of(kc[c])-1]);
      if (capture && ov[c] && ncap[c] < 8) begin
        cap[c][ncap[c]] = oc[c];
        ncap[c]++;
      end
    end
  endtask

  task automatic tick(input logic [2:0] v, input logic [2:0] d);
    @(negedge clk);
    check_outputs();
    vin = v;
    din = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    check_outputs();
    rst_n = 1'b0;
    vin = 3'b0;
    #1;
    for (int c = 0; c < 3; c++) begin
      chk(ov[c] == 1'b0, "R10 out_valid async clear", {7'd0, ov[c]}, 8'd0);
      chk(rdy[c] == 1'b0, "R10 in_ready async clear", {7'd0, rdy[c]}, 8'd0);
    end
    clear_model();
    repeat (3) tick(3'b0, 3'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    #(8 * 200000);
    nfail++;
    nchk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin : main
    int first [3];
    logic [7:0] kat_a [6];
    logic [7:0] kat_b [7];
    logic [5:0] seq_a;
    logic [6:0] seq_b;
    clear_model();
    kat_a = '{8'd3, 8'd1, 8'd0, 8'd2, 8'd2, 8'd3};
    kat_b = '{8'd3, 8'd1, 8'd3, 8'd3, 8'd0, 8'd2, 8'd3};

    // Reset state (R8, R9) and release
    do_reset();
    tick(3'b0, 3'b0);

    // R6: latency from a single accepted word
    tick(3'b111, 3'b111);
    for (int c = 0; c < 3; c++) first[c] = -1;
    for (int s = 1; s <= 5; s++) begin
      tick(3'b0, 3'b0);
      for (int c = 0; c < 3; c++) if (ov[c] && first[c] < 0) first[c] = s;
    end
    for (int c = 0; c < 3; c++)
      chk(first[c] == lat_of(kc[c]), "R6 latency", first[c][7:0], lat_of(kc[c]));

    // R4 / R5 known sequences from the zero state (R1)
    do_reset();
    tick(3'b0, 3'b0);
    for (int c = 0; c < 3; c++) ncap[c] = 0;
    capture = 1;
    seq_a = 6'b001101;   // sent LSB first: 1,0,1,1,0,0
    seq_b = 7'b0000001;  // impulse
    for (int i = 0; i < 7; i++)
      tick(3'b111, {1'b1, seq_b[i], (i < 6) ? seq_a[i] : 1'b0});
    repeat (5) tick(3'b0, 3'b0);
    capture = 0;
    for (int i = 0; i < 6; i++)
      chk(cap[0][i] == kat_a[i], "R4 (R1 zero start) K3 sequence", cap[0][i], kat_a[i]);
    for (int i = 0; i < 7; i++)
      chk(cap[1][i] == kat_b[i], "R5 (R1 zero start) K7 impulse", cap[1][i], kat_b[i]);

    // R7: random stream with idle gaps, din toggling while idle
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] v;
      for (int c = 0; c < 3; c++) v[c] = ($urandom % 4) != 0;
      tick(v, 3'($urandom));
    end

    // Exhaustive 6-bit patterns, back to back
    for (int w = 0; w < 64; w++)
      for (int b = 0; b < 6; b++) tick(3'b111, {3{w[b]}});

    // R10: reset with a full pipeline, then resume
    do_reset();
    for (int i = 0; i < 300; i++) tick(3'($urandom), 3'($urandom));
    repeat (6) tick(3'b0, 3'b0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule